// File: doc/BRIEF.md
# Two-Level Address Translation Walker

The walker turns a 32-bit linear address into a physical address by reading a two-level, 32-bit-entry page table through a single word-wide memory port. A requester presents the linear address with an access kind (read, write or instruction fetch) and a user/supervisor flag. The walker fetches the directory entry and, for a small (4 KB) mapping, the table entry. It applies the present, user and writable checks and stores back the accessed and dirty flags it changes. It then ends the walk with a one-cycle completion pulse that carries either a physical address with its granted rights or a page-fault code.

The control inputs are sampled in the cycle a request is taken: a paging enable, a directory base address, a large-page enable, a supervisor write-protect enable and an address-bit-20 enable. With paging off the address passes straight through. With the large-page enable on, a directory entry that marks itself as a large mapping covers 4 MB on its own. Every address the walker produces is masked with the bit-20 mask, both the entry addresses and the final physical address.

Top module: `xlat_walker`

## Requirements
- R1: With paging disabled at acceptance, the walk completes without any memory access. phys_addr is the linear address ANDed with the bit-20 mask, and both grant_wr and grant_user are 1.
- R2: The directory entry is read from ((dir_base with bits 11:0 cleared) + (linear[31:22] * 4)) ANDed with the bit-20 mask.
- R3: For a small page, the table entry is read from ((directory entry with bits 11:0 cleared) + (linear[21:12] * 4)) ANDed with the bit-20 mask.
- R4: If directory entry bit 7 is set and the large-page enable is 1, no table entry is read. phys_addr is then {directory[31:22], linear[21:0]}. With the enable at 0, bit 7 is ignored and a table entry is read.
- R5: An entry with bit 0 clear ends the walk with fault=1 and fault_code bit 0 = 0. fault_code bit 1 is 1 for a write access (req_kind 1), and bit 2 is 1 for a user access. Read (0) and fetch (2) count as non-writes.
- R6: A user access faults with fault_code bit 0 = 1 if the effective user bit (bit 2) is 0, or if it is a write and the effective writable bit (bit 1) is 0. For a small page, the effective bits are the AND of the directory and table bits.
- R7: A supervisor write faults on effective writable bit 0 only when the write-protect enable is 1. Supervisor reads and fetches never fault on rights.
- R8: The accessed bit (bit 5) is set in every entry used, and the dirty bit (bit 6) in the final entry on a write. An entry is written back only if its value changes. The directory write-back happens before the table read, and no final entry is updated on a rights fault.
- R9: With the bit-20 enable at 0, bit 20 of every entry address and of phys_addr is 0.
- R10: done is high for exactly one cycle per accepted request. A req_valid seen while a walk is in progress is ignored.
- R11: On success, a small page gives phys_addr = {table[31:12], linear[11:0]}. grant_user is the effective user bit. grant_wr is 1 only if the final entry is dirty after update, and either the effective writable bit is 1 or (for a supervisor access) the write-protect enable is 0.
- R12: mem_valid stays high with stable mem_addr, mem_we and mem_wdata until mem_ready is seen. A transfer takes place on a clock edge where both are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when the walker is idle |
| req_lin | input | 32 | Linear address to translate |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch |
| req_user | input | 1 | 1 for a user-mode access |
| pg_en | input | 1 | Paging enable |
| wp_en | input | 1 | Supervisor write-protect enable |
| pse_en | input | 1 | Large-page enable |
| a20_en | input | 1 | Address bit 20 enable |
| dir_base | input | 32 | Directory base address |
| mem_valid | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory word address (byte address) |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts / returns data this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Walk ended in a page fault |
| fault_code | output | 3 | {user, write, protection} |
| phys_addr | output | 32 | Translated address, 0 on fault |
| grant_wr | output | 1 | Writes allowed through this mapping |
| grant_user | output | 1 | User accesses allowed through this mapping |

## Verification
The assertions assume that the memory raises mem_ready only while mem_valid is high. They also assume that mem_rdata carries the addressed word in that same cycle. The bench responder meets both. It raises ready only after it has sampled a pending request, with a latency that cycles through zero to two wait cycles. It loads the read data in the same edge as ready and drops ready right after each transfer. The stimulus changes the control inputs only while the walker is idle, so the sampled configuration is the one each check expects.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int unsigned VA_W   = 32;
  localparam int unsigned OFS_W  = 12;
  localparam int unsigned IDX_W  = 10;
  localparam int unsigned BIG_W  = OFS_W + IDX_W;
  localparam int unsigned A20_BIT = 20;

  localparam int unsigned B_PRES  = 0;
  localparam int unsigned B_RW    = 1;
  localparam int unsigned B_USR   = 2;
  localparam int unsigned B_ACC   = 5;
  localparam int unsigned B_DIRTY = 6;
  localparam int unsigned B_BIG   = 7;

  typedef logic [VA_W-1:0] word_t;

  localparam word_t OFS_MASK  = word_t'((64'd1 << OFS_W) - 64'd1);
  localparam word_t BIG_MASK  = word_t'((64'd1 << BIG_W) - 64'd1);
  localparam word_t SLOT_MASK = word_t'(((64'd1 << IDX_W) - 64'd1) << 2);

  typedef enum logic [2:0] {
    S_IDLE, S_RD_DIR, S_WR_DIR, S_RD_TBL, S_WR_TBL, S_DONE
  } walk_st_t;

  typedef enum logic [1:0] {
    ACC_READ = 2'd0, ACC_WRITE = 2'd1, ACC_FETCH = 2'd2
  } acc_kind_t;

  function automatic word_t a20_mask(input logic en);
    word_t m;
    m = '1;
    m[A20_BIT] = en;
    return m;
  endfunction

  function automatic word_t dir_slot(input word_t root, input word_t lin, input word_t m);
    return ((root & ~OFS_MASK) + ((lin >> (BIG_W - 2)) & SLOT_MASK)) & m;
  endfunction

  function automatic word_t tbl_slot(input word_t dir, input word_t lin, input word_t m);
    return ((dir & ~OFS_MASK) + ((lin >> (OFS_W - 2)) & SLOT_MASK)) & m;
  endfunction

  function automatic word_t join_phys(input word_t frame, input word_t lin,
                                      input word_t ofs_m, input word_t m);
    return ((frame & ~ofs_m) | (lin & ofs_m)) & m;
  endfunction
endpackage

// File: rtl/xlat_entry_upd.sv
module xlat_entry_upd
  import xlat_pkg::*;
(
  input  word_t entry_in,
  input  logic  set_dirty,
  output word_t entry_out,
  output logic  changed
);
  always_comb begin
    entry_out = entry_in;
    entry_out[B_ACC] = 1'b1;
    if (set_dirty) entry_out[B_DIRTY] = 1'b1;
  end
  assign changed = (entry_out != entry_in);
endmodule

// File: rtl/xlat_perm.sv
module xlat_perm (
  input  logic eff_usr,
  input  logic eff_rw,
  input  logic is_user,
  input  logic is_write,
  input  logic wp,
  input  logic final_dirty,
  output logic deny,
  output logic wr_grant
);
  logic rw_ok;
  assign rw_ok    = is_user ? eff_rw : (eff_rw || !wp);
  assign deny     = is_user ? (!eff_usr || (is_write && !eff_rw))
                            : (is_write && wp && !eff_rw);
  assign wr_grant = final_dirty && rw_ok;
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xlat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_lin,
  input  logic [1:0]        req_kind,
  input  logic              req_user,
  input  logic              pg_en,
  input  logic              wp_en,
  input  logic              pse_en,
  input  logic              a20_en,
  input  logic [VA_W-1:0]   dir_base,
  output logic              mem_valid,
  output logic              mem_we,
  output logic [VA_W-1:0]   mem_addr,
  output logic [VA_W-1:0]   mem_wdata,
  input  logic              mem_ready,
  input  logic [VA_W-1:0]   mem_rdata,
  output logic              done,
  output logic              fault,
  output logic [2:0]        fault_code,
  output logic [VA_W-1:0]   phys_addr,
  output logic              grant_wr,
  output logic              grant_user
);
  walk_st_t st;
  word_t lin_q, addr_q, wdata_q, dir_q, a20m_q, last_rd_q;
  logic  wr_q, usr_q, wp_q, pse_q, big_q;

  // named internal events
  logic  xfer_fire, ent_present, big_pg, in_tbl;
  logic  eff_usr, eff_rw, upd_changed, deny, wr_grant;
  word_t upd_entry;

  assign xfer_fire   = mem_valid && mem_ready;
  assign ent_present = mem_rdata[B_PRES];
  assign in_tbl      = (st == S_RD_TBL);
  assign big_pg      = !in_tbl && mem_rdata[B_BIG] && pse_q;
  assign eff_usr     = in_tbl ? (dir_q[B_USR] & mem_rdata[B_USR]) : mem_rdata[B_USR];
  assign eff_rw      = in_tbl ? (dir_q[B_RW]  & mem_rdata[B_RW])  : mem_rdata[B_RW];

  xlat_entry_upd u_upd (
    .entry_in  (mem_rdata),
    .set_dirty (wr_q && (in_tbl || big_pg)),
    .entry_out (upd_entry),
    .changed   (upd_changed)
  );

  xlat_perm u_perm (
    .eff_usr     (eff_usr),
    .eff_rw      (eff_rw),
    .is_user     (usr_q),
    .is_write    (wr_q),
    .wp          (wp_q),
    .final_dirty (upd_entry[B_DIRTY]),
    .deny        (deny),
    .wr_grant    (wr_grant)
  );

  assign mem_valid = (st == S_RD_DIR) || (st == S_WR_DIR) ||
                     (st == S_RD_TBL) || (st == S_WR_TBL);
  assign mem_we    = (st == S_WR_DIR) || (st == S_WR_TBL);
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
  assign done      = (st == S_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      lin_q <= '0; addr_q <= '0; wdata_q <= '0; dir_q <= '0;
      a20m_q <= '1; last_rd_q <= '0;
      wr_q <= 1'b0; usr_q <= 1'b0; wp_q <= 1'b0; pse_q <= 1'b0; big_q <= 1'b0;
      fault <= 1'b0; fault_code <= '0; phys_addr <= '0;
      grant_wr <= 1'b0; grant_user <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          lin_q  <= req_lin;
          wr_q   <= (req_kind == ACC_WRITE);
          usr_q  <= req_user;
          wp_q   <= wp_en;
          pse_q  <= pse_en;
          a20m_q <= a20_mask(a20_en);
          if (pg_en) begin
            addr_q <= dir_slot(dir_base, req_lin, a20_mask(a20_en));
            st     <= S_RD_DIR;
          end else begin
            fault      <= 1'b0;
            fault_code <= '0;
            phys_addr  <= req_lin & a20_mask(a20_en);
            grant_wr   <= 1'b1;
            grant_user <= 1'b1;
            st         <= S_DONE;
          end
        end
        S_RD_DIR: if (xfer_fire) begin
          last_rd_q <= mem_rdata;
          if (!ent_present || (big_pg && deny)) begin
            fault      <= 1'b1;
            fault_code <= {usr_q, wr_q, ent_present};
            phys_addr  <= '0;
            grant_wr   <= 1'b0;
            grant_user <= 1'b0;
            st         <= S_DONE;
          end else if (big_pg) begin
            big_q      <= 1'b1;
            fault      <= 1'b0;
            fault_code <= '0;
            phys_addr  <= join_phys(mem_rdata, lin_q, BIG_MASK, a20m_q);
            grant_wr   <= wr_grant;
            grant_user <= eff_usr;
            wdata_q    <= upd_entry;
            st         <= upd_changed ? S_WR_DIR : S_DONE;
          end else begin
            big_q   <= 1'b0;
            dir_q   <= upd_entry;
            wdata_q <= upd_entry;
            if (upd_changed) st <= S_WR_DIR;
            else begin
              addr_q <= tbl_slot(upd_entry, lin_q, a20m_q);
              st     <= S_RD_TBL;
            end
          end
        end
        S_WR_DIR: if (xfer_fire) begin
          if (big_q) st <= S_DONE;
          else begin
            addr_q <= tbl_slot(dir_q, lin_q, a20m_q);
            st     <= S_RD_TBL;
          end
        end
        S_RD_TBL: if (xfer_fire) begin
          last_rd_q <= mem_rdata;
          if (!ent_present || deny) begin
            fault      <= 1'b1;
            fault_code <= {usr_q, wr_q, ent_present};
            phys_addr  <= '0;
            grant_wr   <= 1'b0;
            grant_user <= 1'b0;
            st         <= S_DONE;
          end else begin
            fault      <= 1'b0;
            fault_code <= '0;
            phys_addr  <= join_phys(mem_rdata, lin_q, OFS_MASK, a20m_q);
            grant_wr   <= wr_grant;
            grant_user <= eff_usr;
            wdata_q    <= upd_entry;
            st         <= upd_changed ? S_WR_TBL : S_DONE;
          end
        end
        S_WR_TBL: if (xfer_fire) st <= S_DONE;
        S_DONE:   st <= S_IDLE;
        default:  st <= S_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R12
  AST_WB_ACCESSED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_we) |-> mem_wdata[B_ACC]); // R8
  AST_WB_CHANGED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_we) |-> (mem_wdata != last_rd_q)); // R8
  AST_A20_PHYS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !a20m_q[A20_BIT]) |-> !phys_addr[A20_BIT]); // R9
  AST_A20_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !a20m_q[A20_BIT]) |-> !mem_addr[A20_BIT]); // R9
endmodule

// File: tb/xlat_walker_tb_top.sv
`timescale 1ns/1ps
module xlat_walker_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [31:0] req_lin = '0;
  logic [1:0] req_kind = '0;
  logic req_user = 1'b0;
  logic pg_en = 1'b0, wp_en = 1'b0, pse_en = 1'b0, a20_en = 1'b1;
  logic [31:0] dir_base = 32'h0000_1000;
  logic mem_valid, mem_we, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic done, fault, grant_wr, grant_user;
  logic [2:0] fault_code;
  logic [31:0] phys_addr;

  always #5 clk = ~clk;

  xlat_walker dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_lin(req_lin),
    .req_kind(req_kind), .req_user(req_user), .pg_en(pg_en), .wp_en(wp_en),
    .pse_en(pse_en), .a20_en(a20_en), .dir_base(dir_base),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .done(done), .fault(fault), .fault_code(fault_code),
    .phys_addr(phys_addr), .grant_wr(grant_wr), .grant_user(grant_user)
  );

  // sparse memory: words below 0x4000 exist, all else reads as zero
  logic [31:0] mem [0:4095];
  int wr_cnt = 0;
  int acc_cnt = 0;
  int wait_c = 0;
  int lat_sel = 0;

  function automatic logic [31:0] rd_word(input logic [31:0] a);
    if (a[31:14] != 18'd0) return 32'd0;
    return mem[a[13:2]];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ready <= 1'b0;
      mem_rdata <= '0;
      wait_c    <= 0;
    end else if (mem_ready) begin
      mem_ready <= 1'b0;
      acc_cnt   <= acc_cnt + 1;
      if (mem_we) begin
        if (mem_addr[31:14] == 18'd0) mem[mem_addr[13:2]] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end
    end else if (mem_valid) begin
      if (wait_c >= lat_sel) begin
        mem_ready <= 1'b1;
        mem_rdata <= rd_word(mem_addr);
        wait_c    <= 0;
        lat_sel   <= (lat_sel + 1) % 3;
      end else wait_c <= wait_c + 1;
    end
  end

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bench reference results
  logic        e_fault, e_wr_ok, e_usr_ok, e_tbl_used;
  logic [2:0]  e_code;
  logic [31:0] e_phys, e_pa, e_ta, e_pde_new, e_pte_new;
  int          e_nwr;

  task automatic model(input logic [31:0] lin, input logic [1:0] kind, input logic usr);
    logic [31:0] m, pde, pte;
    logic wr, u, rw, den;
    m = a20_en ? 32'hFFFF_FFFF : 32'hFFEF_FFFF;
    wr = (kind == 2'd1);
    e_fault = 0; e_code = 0; e_phys = 0; e_wr_ok = 0; e_usr_ok = 0;
    e_nwr = 0; e_tbl_used = 0;
    e_pa = 0; e_ta = 0; e_pde_new = 0; e_pte_new = 0;
    if (!pg_en) begin
      e_phys = lin & m; e_wr_ok = 1; e_usr_ok = 1;
      return;
    end
    e_pa = ({dir_base[31:12], 12'h000} + {20'h0, lin[31:22], 2'b00}) & m;
    pde = rd_word(e_pa);
    e_pde_new = pde;
    if (!pde[0]) begin
      e_fault = 1; e_code = {usr, wr, 1'b0};
    end else if (pde[7] && pse_en) begin
      u = pde[2]; rw = pde[1];
      den = usr ? (!u || (wr && !rw)) : (wr && wp_en && !rw);
      if (den) begin
        e_fault = 1; e_code = {usr, wr, 1'b1};
      end else begin
        e_pde_new = pde | 32'h20 | (wr ? 32'h40 : 32'h0);
        e_nwr = (e_pde_new != pde) ? 1 : 0;
        e_phys = {pde[31:22], lin[21:0]} & m;
        e_usr_ok = u;
        e_wr_ok = e_pde_new[6] && (usr ? rw : (!wp_en || rw));
      end
    end else begin
      e_pde_new = pde | 32'h20;
      e_nwr = (e_pde_new != pde) ? 1 : 0;
      e_tbl_used = 1;
      e_ta = ({pde[31:12], 12'h000} + {20'h0, lin[21:12], 2'b00}) & m;
      pte = rd_word(e_ta);
      e_pte_new = pte;
      if (!pte[0]) begin
        e_fault = 1; e_code = {usr, wr, 1'b0};
      end else begin
        u = pde[2] & pte[2]; rw = pde[1] & pte[1];
        den = usr ? (!u || (wr && !rw)) : (wr && wp_en && !rw);
        if (den) begin
          e_fault = 1; e_code = {usr, wr, 1'b1};
        end else begin
          e_pte_new = pte | 32'h20 | (wr ? 32'h40 : 32'h0);
          if (e_pte_new != pte) e_nwr++;
          e_phys = {pte[31:12], lin[11:0]} & m;
          e_usr_ok = u;
          e_wr_ok = e_pte_new[6] && (usr ? rw : (!wp_en || rw));
        end
      end
    end
  endtask

  task automatic walk(input logic [31:0] lin, input logic [1:0] kind, input logic usr,
                      input bit poke, input string tag);
    int w0, a0, guard;
    logic [31:0] ph;
    model(lin, kind, usr);
    w0 = wr_cnt; a0 = acc_cnt;
    req_lin = lin; req_kind = kind; req_user = usr; req_valid = 1'b1;
    @(negedge clk);
    if (poke && pg_en) begin
      // R10: a request during the walk must be ignored
      req_lin = ~lin; req_kind = 2'd1; req_user = ~usr;
      @(negedge clk);
    end
    req_valid = 1'b0;
    guard = 0;
    while (!done && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    chk(guard < 100, "R10 completion seen", guard, 0);
    chk(fault == e_fault, {tag, " R5 fault flag"}, fault, e_fault);
    chk(fault_code == e_code, {tag, " R6 R7 fault code"}, fault_code, e_code);
    chk(phys_addr == e_phys, {tag, " R11 R4 R9 phys"}, phys_addr, e_phys);
    chk(grant_wr == e_wr_ok, {tag, " R11 grant_wr"}, grant_wr, e_wr_ok);
    chk(grant_user == e_usr_ok, {tag, " R11 grant_user"}, grant_user, e_usr_ok);
    chk((wr_cnt - w0) == e_nwr, {tag, " R8 write-back count"}, wr_cnt - w0, e_nwr);
    if (pg_en) begin
      if (e_pa[31:14] == 0)
        chk(rd_word(e_pa) == e_pde_new, {tag, " R8 R2 directory entry"}, rd_word(e_pa), e_pde_new);
      if (e_tbl_used && e_ta[31:14] == 0)
        chk(rd_word(e_ta) == e_pte_new, {tag, " R8 R3 table entry"}, rd_word(e_ta), e_pte_new);
    end else
      chk(acc_cnt == a0, {tag, " R1 no memory access"}, acc_cnt - a0, 0);
    ph = phys_addr;
    @(negedge clk);
    chk(!done, {tag, " R10 single-cycle done"}, done, 0);
    chk(phys_addr == ph, {tag, " R10 result held"}, phys_addr, ph);
  endtask

  task automatic put(input logic [31:0] a, input logic [31:0] v);
    mem[a[13:2]] = v;
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(!done && !mem_valid, "R10 R12 reset state", {30'd0, done, mem_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 passthrough with both A20 settings
    pg_en = 0; a20_en = 1;
    walk(32'h0013_5ABC, 2'd1, 1'b1, 0, "R1 pass a20=1");
    a20_en = 0;
    walk(32'h0013_5ABC, 2'd0, 1'b0, 0, "R1 R9 pass a20=0");
    a20_en = 1;

    // near-exhaustive sweep of entry flags, access kind, mode and WP
    pg_en = 1; dir_base = 32'h0000_1000;
    begin
      int n;
      n = 0;
      for (int ps = 0; ps < 2; ps++)
        for (int df = 0; df < 16; df++)
          for (int tf = 0; tf < 8; tf++)
            for (int k = 0; k < 3; k++)
              for (int us = 0; us < 2; us++)
                for (int wp = 0; wp < 2; wp++) begin
                  logic [31:0] lin, pdev, ptev, pa, ta;
                  int ad;
                  ad = (n * 7) % 4;
                  lin = n[0] ? 32'h00C0_7FF0 : 32'h0052_3ABC;
                  pdev = 32'h0000_2000 | {24'h0, df[3], ad[1], ad[0], 2'b00, df[2], df[1], df[0]};
                  ptev = 32'h0013_5000 | {25'h0, ad[0] ^ ad[1], ad[1], 2'b00, tf[2], tf[1], tf[0]};
                  pa = 32'h0000_1000 + {20'h0, lin[31:22], 2'b00};
                  ta = 32'h0000_2000 + {20'h0, lin[21:12], 2'b00};
                  put(pa, pdev); put(ta, ptev);
                  pse_en = ps[0]; wp_en = wp[0];
                  walk(lin, k[1:0], us[0], (n % 5) == 0, "sweep");
                  n++;
                end
    end

    // R4 large page with high frame bits, A20 off clears bit 20
    pse_en = 1; wp_en = 1; a20_en = 0;
    put(32'h0000_1004, 32'hFFC0_0087);
    walk(32'h0052_3ABC, 2'd1, 1'b0, 0, "R4 R9 big frame");
    // R2 R9 directory base with bit 20 set aliases onto 0x1000 when A20 off
    dir_base = 32'h0010_1000;
    put(32'h0000_1004, 32'h0010_2007);
    put(32'h0000_248C, 32'h0013_5007);
    walk(32'h0052_3ABC, 2'd0, 1'b1, 0, "R2 R3 R9 a20=0");
    // R9 with A20 on the same base points at unmapped space: not present
    a20_en = 1;
    walk(32'h0052_3ABC, 2'd0, 1'b1, 0, "R2 R5 R9 a20=1");
    // R12 covered by every walk above through the variable-latency responder
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule